// File: doc/BRIEF.md
# Zero-Crossing FM Demodulator

This block turns a digitised FM signal at an intermediate frequency into baseband amplitude samples. It does not differentiate, discriminate or multiply. It divides the valid input samples into windows of fixed length and counts how often the sign of the signal flips inside each window. When a window closes, it subtracts a reference count from that tally. The reference is the number of flips an unmodulated carrier at the centre frequency would give. The signed difference is one recovered baseband sample. The stream of these differences is the demodulated signal.

The window length, measured in valid samples, and the reference count can both be loaded while the block runs. Each has a parameterised default that is used after reset. Loading a new configuration restarts the window from an empty state. A result pulse appears once per window. Between pulses the output word holds its last value.

Top module: `zc_fm_demod`

## Requirements
- R1: A crossing is a change of the sign bit (bit SAMPLE_W-1 of `in_sample`) between two consecutive accepted samples. A sample equal to zero counts as non-negative, so 0 followed by a positive value is not a crossing, and 0 followed by a negative value is a crossing.
- R2: The first accepted sample after reset, or after a configuration load, never counts as a crossing.
- R3: A window closes on its N-th accepted sample, where N is the active window length. Cycles with `in_valid` low change no state and do not advance the window.
- R4: At window close, `out_data` becomes the crossing count minus the reference, as a two's-complement value CNT_W+1 bits wide. It keeps that value until the next window closes.
- R5: `out_valid` is high for exactly one cycle per window, in the cycle right after the clock edge that accepts the closing sample.
- R6: A crossing formed by the closing sample and the sample before it is not counted in the window that closes. The next window's count starts at 1 in that case and at 0 otherwise.
- R7: When `cfg_load` is high, `cfg_win` and `cfg_ref` are captured, the partial window is discarded without producing a result, and any `in_sample` presented in that same cycle is ignored.
- R8: Loading a window length of 0 gives a window of 1 sample.
- R9: After reset the window length is DEF_WIN, the reference is DEF_REF, `out_valid` is 0 and `out_data` is 0.
- R10: Counts up to 2^CNT_W-1 are reported without wrap. The outputs span -(2^CNT_W-1) to +(2^CNT_W-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | `in_sample` is valid this cycle |
| in_sample | input | SAMPLE_W | Signed IF sample |
| cfg_load | input | 1 | Capture `cfg_win` and `cfg_ref` and restart the window |
| cfg_win | input | CNT_W | Window length in accepted samples (0 means 1) |
| cfg_ref | input | CNT_W | Reference count for zero modulation |
| out_valid | output | 1 | One-cycle pulse per window result |
| out_data | output | CNT_W+1 | Signed count minus reference |

## Verification
The hardest case to reach is the top of the count range. A window must be as long as the counter allows and must have a crossing on every sample pair. Only then does the count reach 2^CNT_W-1, with the carried-over crossing from the previous window filling the last slot. The stimulus loads a window of 1023 with a zero reference and feeds strictly alternating signs for several windows. It then loads a reference of 1023 and holds a constant sign, which drives the output to its most negative value. Random stretches with bursty `in_valid`, runs of zero-valued samples and loads in the middle of a window cover the carry-over rule and the restart rule.

// File: rtl/zc_pkg.sv
package zc_pkg;
  // Sign bit change between two accepted samples; no history means no crossing.
  function automatic logic zc_crossed(input logic have_prev,
                                      input logic prev_neg,
                                      input logic cur_neg);
    return have_prev & (prev_neg ^ cur_neg);
  endfunction
endpackage

// File: rtl/zc_sign_track.sv
module zc_sign_track #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_ok,
  input  logic                restart,
  input  logic [SAMPLE_W-1:0] smp,
  output logic                xing
);
  import zc_pkg::*;

  logic have_prev;
  logic prev_neg;
  logic cur_neg;

  assign cur_neg = smp[SAMPLE_W-1];
  assign xing    = smp_ok & zc_crossed(have_prev, prev_neg, cur_neg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_neg  <= 1'b0;
    end else if (restart) begin
      have_prev <= 1'b0;
      prev_neg  <= 1'b0;
    end else if (smp_ok) begin
      have_prev <= 1'b1;
      prev_neg  <= cur_neg;
    end
  end

  // R2
  history_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !have_prev);

  // R1
  sign_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ok && !restart) |=> (have_prev && prev_neg == $past(smp[SAMPLE_W-1])));
endmodule

// File: rtl/zc_window_ctl.sv
module zc_window_ctl #(
  parameter int CNT_W   = 10,
  parameter int DEF_WIN = 64,
  parameter int DEF_REF = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_ok,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_win,
  input  logic [CNT_W-1:0] cfg_ref,
  output logic             win_last,
  output logic [CNT_W-1:0] ref_val
);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] WIN_INIT = (DEF_WIN < 1) ? ONE : CNT_W'(DEF_WIN);
  localparam logic [CNT_W-1:0] REF_INIT = CNT_W'(DEF_REF);

  logic [CNT_W-1:0] win_len;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] win_next;

  assign win_next = (cfg_win == '0) ? ONE : cfg_win;
  assign win_last = smp_ok & (idx == (win_len - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_len <= WIN_INIT;
      ref_val <= REF_INIT;
      idx     <= '0;
    end else if (cfg_load) begin
      win_len <= win_next;
      ref_val <= cfg_ref;
      idx     <= '0;
    end else if (smp_ok) begin
      idx <= win_last ? '0 : idx + ONE;
    end
  end

  // R3
  idx_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx < win_len);

  // R8
  load_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (idx == '0 && win_len != '0));
endmodule

// File: rtl/zc_accum.sv
module zc_accum #(
  parameter int CNT_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               smp_ok,
  input  logic               xing,
  input  logic               win_last,
  input  logic [CNT_W-1:0]   ref_val,
  output logic               out_valid,
  output logic [CNT_W:0]     out_data
);
  localparam int OUT_W = CNT_W + 1;

  // Signed difference of two unsigned counts, one bit wider than either.
  function automatic logic [OUT_W-1:0] zc_diff(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= win_last;
      if (restart) begin
        cnt <= '0;
      end else if (smp_ok) begin
        if (win_last) begin
          out_data <= zc_diff(cnt, ref_val);
          cnt      <= {{(CNT_W-1){1'b0}}, xing};
        end else begin
          cnt <= cnt + {{(CNT_W-1){1'b0}}, xing};
        end
      end
    end
  end

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ok && !win_last && !restart) |=> cnt >= $past(cnt));

  // R6
  carry_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && !restart) |=> cnt <= CNT_W'(1));
endmodule

// File: rtl/zc_fm_demod.sv
module zc_fm_demod #(
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 10,
  parameter int DEF_WIN  = 64,
  parameter int DEF_REF  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                cfg_load,
  input  logic [CNT_W-1:0]    cfg_win,
  input  logic [CNT_W-1:0]    cfg_ref,
  output logic                out_valid,
  output logic [CNT_W:0]      out_data
);
  logic             smp_ok;
  logic             xing;
  logic             win_last;
  logic [CNT_W-1:0] ref_val;

  assign smp_ok = in_valid & ~cfg_load;

  zc_sign_track #(.SAMPLE_W(SAMPLE_W)) u_sign (
    .clk(clk), .rst_n(rst_n), .smp_ok(smp_ok), .restart(cfg_load),
    .smp(in_sample), .xing(xing)
  );

  zc_window_ctl #(.CNT_W(CNT_W), .DEF_WIN(DEF_WIN), .DEF_REF(DEF_REF)) u_win (
    .clk(clk), .rst_n(rst_n), .smp_ok(smp_ok), .cfg_load(cfg_load),
    .cfg_win(cfg_win), .cfg_ref(cfg_ref), .win_last(win_last), .ref_val(ref_val)
  );

  zc_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .restart(cfg_load), .smp_ok(smp_ok),
    .xing(xing), .win_last(win_last), .ref_val(ref_val),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && !cfg_load));

  // R7
  load_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !out_valid);
endmodule

// File: tb/tb_zc_fm_demod.sv
module tb_zc_fm_demod;
  localparam int SW = 12;
  localparam int CW = 10;
  localparam int DW = 16;
  localparam int DR = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_sample = '0;
  logic          cfg_load = 1'b0;
  logic [CW-1:0] cfg_win = '0;
  logic [CW-1:0] cfg_ref = '0;
  logic          out_valid;
  logic [CW:0]   out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R9";

  // reference model state
  bit m_have = 0;
  bit m_neg = 0;
  int m_cnt = 0;
  int m_idx = 0;
  int m_win = DW;
  int m_ref = DR;
  bit exp_pulse = 0;
  int exp_val = 0;
  int held = 0;

  zc_fm_demod #(.SAMPLE_W(SW), .CNT_W(CW), .DEF_WIN(DW), .DEF_REF(DR)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_load(cfg_load), .cfg_win(cfg_win), .cfg_ref(cfg_ref),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2 clk = ~clk;

  function automatic bit is_neg(input logic [SW-1:0] s);
    return s[SW-1];
  endfunction

  task automatic check(input bit ok, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic compare_outputs();
    int got;
    got = $signed(out_data);
    check(out_valid == exp_pulse, "out_valid (R5)", int'(out_valid), int'(exp_pulse));
    if (exp_pulse) held = exp_val;
    check(got == held, "out_data (R4)", got, held);
  endtask

  task automatic step(input bit v, input logic [SW-1:0] s, input bit ld,
                      input int w, input int r);
    bit x;
    bit n;
    @(negedge clk);
    compare_outputs();
    in_valid  = v;
    in_sample = s;
    cfg_load  = ld;
    cfg_win   = CW'(w);
    cfg_ref   = CW'(r);
    exp_pulse = 0;
    if (ld) begin
      m_win = (w == 0) ? 1 : w;
      m_ref = r;
      m_idx = 0;
      m_cnt = 0;
      m_have = 0;
    end else if (v) begin
      n = is_neg(s);
      x = m_have && (n != m_neg);
      m_have = 1;
      m_neg = n;
      if (m_idx == m_win - 1) begin
        exp_pulse = 1;
        exp_val = m_cnt - m_ref;
        m_cnt = int'(x);
        m_idx = 0;
      end else begin
        m_cnt += int'(x);
        m_idx++;
      end
    end
  endtask

  task automatic smp(input logic [SW-1:0] s);
    step(1, s, 0, 0, 0);
  endtask

  task automatic load(input int w, input int r);
    step(0, '0, 1, w, r);
  endtask

  function automatic logic [SW-1:0] rnd_sample();
    int k;
    k = $urandom_range(0, 9);
    if (k == 0) return '0;
    return SW'($urandom);
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    tag = "R9";
    check(out_valid == 1'b0, "reset out_valid", int'(out_valid), 0);
    check($signed(out_data) == 0, "reset out_data", $signed(out_data), 0);
    // R9 default window of DW with reference DR
    for (int i = 0; i < 2 * DW; i++) smp((i % 3 == 0) ? SW'(-5) : SW'(7));

    // R1: zeros count as non-negative
    tag = "R1";
    load(6, 0);
    smp(SW'(5)); smp('0); smp(SW'(-1)); smp('0); smp('0); smp(SW'(3));
    smp('0); smp(SW'(-8)); smp(SW'(-1)); smp('0); smp(SW'(9)); smp('0);

    // R2: first sample after load has no predecessor
    tag = "R2";
    smp(SW'(-3));
    load(3, 1);
    smp(SW'(4)); smp(SW'(4)); smp(SW'(4));

    // R3: gaps in in_valid do not advance the window
    tag = "R3";
    load(5, 2);
    for (int i = 0; i < 40; i++)
      step($urandom_range(0, 2) != 0, rnd_sample(), 0, 0, 0);

    // R6: window of 1 with alternating signs carries every crossing
    tag = "R6";
    load(1, 0);
    for (int i = 0; i < 10; i++) smp((i % 2) ? SW'(-2) : SW'(2));
    load(4, 1);
    smp(SW'(1)); smp(SW'(1)); smp(SW'(1)); smp(SW'(-1));
    smp(SW'(-1)); smp(SW'(-1)); smp(SW'(-1)); smp(SW'(-1));

    // R7: load mid-window, and a load with in_valid high drops that sample
    tag = "R7";
    load(8, 3);
    for (int i = 0; i < 5; i++) smp((i % 2) ? SW'(-9) : SW'(9));
    step(1, SW'(-9), 1, 4, 0);
    for (int i = 0; i < 9; i++) smp((i % 2) ? SW'(6) : SW'(-6));

    // R8: window 0 acts as 1
    tag = "R8";
    load(0, 0);
    for (int i = 0; i < 6; i++) smp((i < 3) ? SW'(1) : SW'(-1));

    // R4: negative results and held output across idle cycles
    tag = "R4";
    load(7, 20);
    for (int i = 0; i < 21; i++) smp(rnd_sample());
    for (int i = 0; i < 5; i++) step(0, rnd_sample(), 0, 0, 0);

    // R10: full-scale counts in both directions
    tag = "R10";
    load(1023, 0);
    for (int i = 0; i < 3 * 1023; i++) smp((i % 2) ? SW'(-100) : SW'(100));
    load(1023, 1023);
    for (int i = 0; i < 1023; i++) smp(SW'(50));

    // Random mix
    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 299) == 0)
        load($urandom_range(0, 40), $urandom_range(0, 40));
      else
        step($urandom_range(0, 3) != 0, rnd_sample(), 0, 0, 0);
    end
    step(0, '0, 0, 0, 0);
    @(negedge clk);
    compare_outputs();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule